// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates between thirteen interrupt request lines on behalf of a CPU core. Each source has its own enable bit and a two-bit priority level assembled from a separate high bit and low bit, and one global enable gates every request at once. Within a single clock the block picks the winning pending request and presents its index and vector address, and it raises the request line to the CPU.

When the CPU takes the interrupt it pulses an acknowledge. The controller then marks the winner's level as in service, and from that point only strictly higher levels can get through. A return pulse retires the most recent level, so that service routines can nest up to four deep.

A separate wakeup output reports enabled pending requests from the sources that may bring the CPU out of power-down. Flags are cleared inside the peripherals, not here.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no level is in service and `irq_o` is 0 while no request is pending. A level-0 request is then accepted at once.
- R2: A source whose bit in `en_i` is 0 never wins and never raises `irq_o`.
- R3: When `glob_en_i` is 0, `irq_o` is 0 whatever the requests are.
- R4: A source's level is `{prio_hi_i[i], prio_lo_i[i]}`, with 3 the highest. Among eligible requests a higher level always beats a lower one.
- R5: Among eligible requests at the same level, the lowest source index wins. Index 0 ranks first and index 12 ranks last.
- R6: While `irq_o` is 1, `src_o` is the winner's index and `vec_o` equals 16'h0003 + 8 × `src_o`.
- R7: An `ack_i` cycle with `irq_o` high marks the winner's level in service. From the next cycle, requests at that level or below do not raise `irq_o`.
- R8: A request at a level strictly above every level in service raises `irq_o` and can be accepted, which nests the routines.
- R9: While level 3 is in service, no request raises `irq_o`.
- R10: A `reti_i` pulse clears only the highest level in service, so that requests above the next lower active level become eligible again.
- R11: If `ack_i` and `reti_i` arrive in the same cycle, the highest in-service level is cleared and the accepted winner's level is set.
- R12: `wake_o` is 1 exactly when some source with a 1 in the wake mask has both its request and its enable set. It ignores `glob_en_i` and the in-service state. The default mask marks sources 0 to 7 as wake-capable and sources 8 to 12 as not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 13 | Pending request flag per source |
| en_i | input | 13 | Per-source enable |
| glob_en_i | input | 1 | Global enable for all sources |
| prio_hi_i | input | 13 | High bit of each source's level |
| prio_lo_i | input | 13 | Low bit of each source's level |
| ack_i | input | 1 | One-cycle pulse: CPU accepts the current winner |
| reti_i | input | 1 | One-cycle pulse: return from the current routine |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the winner |
| src_o | output | 4 | Index of the winning source |
| wake_o | output | 1 | Power-down wakeup request |

## Verification
The bench builds the block with its default parameters: thirteen sources, a base vector of 0003h, a step of eight, and wake capability on sources 0 to 7. At these values the last rank position (index 12) and the top vector 0063h can be reached. Both sides of the wake mask boundary, between index 7 and index 8, can be driven. All four in-service bits can also be set, so every nesting depth and the fully blocked level-3 state are exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] isr_t;

    typedef struct packed {
        isr_t active;
    } svc_state_t;
endpackage

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_pkg::*;
#(
    parameter int N = 13
) (
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0]        en_i,
    input  logic                glob_en_i,
    input  logic [N-1:0]        prio_hi_i,
    input  logic [N-1:0]        prio_lo_i,
    input  isr_t                isr_i,
    output logic [N-1:0][LVL_W-1:0] lvl_o,
    output logic [N-1:0]        elig_o
);
    lvl_t top_lvl;
    logic any_active;

    always_comb begin
        top_lvl    = '0;
        any_active = |isr_i;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (isr_i[l]) top_lvl = lvl_t'(l);
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        assign lvl_o[g]  = {prio_hi_i[g], prio_lo_i[g]};
        assign elig_o[g] = req_i[g] & en_i[g] & glob_en_i &
                           (!any_active || (lvl_o[g] > top_lvl));
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N     = 13,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        elig_i,
    input  logic [N-1:0][LVL_W-1:0] lvl_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o,
    output lvl_t                lvl_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (elig_i[i] && lvl_i[i] == lvl_t'(l)) begin
                    found_o = 1'b1;
                    idx_o   = IDX_W'(i);
                    lvl_o   = lvl_t'(l);
                end
            end
        end
    end

    // R5
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> elig_i[idx_o]);

    // R4
    winner_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (lvl_i[idx_o] == lvl_o));
endmodule

// File: rtl/irq_isr.sv
module irq_isr
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  lvl_t take_lvl_i,
    input  logic reti_i,
    output isr_t isr_o
);
    svc_state_t st_d, st_q;
    isr_t       top_oh;

    always_comb begin
        top_oh = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (st_q.active[l]) top_oh = isr_t'(1) << l;
        end
        st_d = st_q;
        if (reti_i) st_d.active = st_d.active & ~top_oh;
        if (take_i) st_d.active = st_d.active | (isr_t'(1) << take_lvl_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_o = st_q.active;

    // R7
    accept_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !reti_i) |=> ($countones(st_q.active) == $countones($past(st_q.active)) + 1));

    // R10
    reti_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !take_i && |st_q.active) |=>
            ($countones(st_q.active) + 1 == $countones($past(st_q.active))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_SRC   = 13,
    parameter int          IDX_W     = $clog2(NUM_SRC),
    parameter int          VEC_W     = 16,
    parameter logic [15:0] VEC_BASE  = 16'h0003,
    parameter int          VEC_STEP  = 8,
    parameter logic [12:0] WAKE_MASK = 13'h00FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               glob_en_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [IDX_W-1:0]   src_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [NUM_SRC-1:0]            elig;
    logic                          found;
    logic [IDX_W-1:0]              win_idx;
    lvl_t                          win_lvl;
    isr_t                          isr;

    irq_level_sel #(.N(NUM_SRC)) u_sel (
        .req_i(req_i), .en_i(en_i), .glob_en_i(glob_en_i),
        .prio_hi_i(prio_hi_i), .prio_lo_i(prio_lo_i),
        .isr_i(isr), .lvl_o(lvl), .elig_o(elig)
    );

    irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig_i(elig), .lvl_i(lvl),
        .found_o(found), .idx_o(win_idx), .lvl_o(win_lvl)
    );

    irq_isr u_isr (
        .clk(clk), .rst_n(rst_n), .take_i(ack_i & found),
        .take_lvl_i(win_lvl), .reti_i(reti_i), .isr_o(isr)
    );

    assign irq_o  = found;
    assign src_o  = win_idx;
    assign vec_o  = VEC_BASE + VEC_W'(VEC_STEP) * VEC_W'(win_idx);
    assign wake_o = |(req_i & en_i & WAKE_MASK[NUM_SRC-1:0]);

    // R3
    glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |-> !irq_o);

    // R2
    enabled_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[src_o] && en_i[src_o]));

    // R9
    top_level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr[NUM_LVL-1] |-> !irq_o);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    localparam int N = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, en = '0, hi = '0, lo = '0;
    logic glob = 1'b0, ack = 1'b0, reti = 1'b0;
    logic irq, wake;
    logic [15:0] vec;
    logic [3:0] src;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .glob_en_i(glob),
        .prio_hi_i(hi), .prio_lo_i(lo), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec), .src_o(src), .wake_o(wake)
    );

    typedef struct packed {
        logic [12:0] req;
        logic [12:0] en;
        logic        glob;
        logic [12:0] hi;
        logic [12:0] lo;
        logic        e_irq;
        logic [3:0]  e_src;
        logic        e_wake;
    } row_t;

    localparam row_t TBL [10] = '{
        '{13'h0020, 13'h1FFF, 1'b1, 13'h0000, 13'h0000, 1'b1, 4'd5,  1'b1},
        '{13'h0020, 13'h1FDF, 1'b1, 13'h0000, 13'h0000, 1'b0, 4'd0,  1'b0},
        '{13'h0004, 13'h1FFF, 1'b0, 13'h0000, 13'h0000, 1'b0, 4'd0,  1'b1},
        '{13'h0202, 13'h1FFF, 1'b1, 13'h0200, 13'h0000, 1'b1, 4'd9,  1'b1},
        '{13'h0810, 13'h1FFF, 1'b1, 13'h0000, 13'h0000, 1'b1, 4'd4,  1'b1},
        '{13'h1400, 13'h1FFF, 1'b1, 13'h0000, 13'h1000, 1'b1, 4'd12, 1'b0},
        '{13'h1FFF, 13'h1FFF, 1'b1, 13'h1FFF, 13'h1FFF, 1'b1, 4'd0,  1'b1},
        '{13'h1FFF, 13'h1FFF, 1'b1, 13'h0080, 13'h0080, 1'b1, 4'd7,  1'b1},
        '{13'h0100, 13'h1FFF, 1'b0, 13'h0000, 13'h0000, 1'b0, 4'd0,  1'b0},
        '{13'h0000, 13'h1FFF, 1'b1, 13'h0000, 13'h0000, 1'b0, 4'd0,  1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic e_irq, input int e_src);
        chk({tag, " irq"}, int'(irq), int'(e_irq));
        if (e_irq) begin
            chk({tag, " src R6"}, int'(src), e_src);
            chk({tag, " vec R6"}, int'(vec), 3 + 8 * e_src);
        end
    endtask

    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] h, input logic [N-1:0] l);
        @(negedge clk);
        req = r; hi = h; lo = l;
        #1;
    endtask

    task automatic pulse(input logic a, input logic r);
        @(negedge clk);
        ack = a; reti = r;
        @(negedge clk);
        ack = 1'b0; reti = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_out("R1 reset idle", 1'b0, 0);
        chk("R12 reset wake", int'(wake), 0);

        foreach (TBL[k]) begin
            @(negedge clk);
            req = TBL[k].req; en = TBL[k].en; glob = TBL[k].glob;
            hi = TBL[k].hi; lo = TBL[k].lo;
            #1;
            expect_out($sformatf("R2/R3/R4/R5 row%0d", k), TBL[k].e_irq, int'(TBL[k].e_src));
            chk($sformatf("R12 wake row%0d", k), int'(wake), int'(TBL[k].e_wake));
        end

        en = '1; glob = 1'b1;
        drive(13'h0008, '0, '0);
        expect_out("R1 level0 accepted", 1'b1, 3);
        pulse(1'b1, 1'b0);
        expect_out("R7 same level held", 1'b0, 0);
        drive(13'h0408, '0, 13'h0400);
        expect_out("R8 preempt by level1", 1'b1, 10);
        pulse(1'b1, 1'b0);
        drive(13'h0C08, '0, 13'h0C00);
        expect_out("R7 level1 held", 1'b0, 0);
        drive(13'h1C08, 13'h1000, 13'h1C00);
        expect_out("R8 level3 preempt", 1'b1, 12);
        pulse(1'b1, 1'b0);
        drive(13'h1C28, 13'h1020, 13'h1C00);
        expect_out("R9 level3 blocks", 1'b0, 0);
        chk("R12 wake ignores isr", int'(wake), 1);
        drive(13'h0C28, 13'h0020, 13'h0C00);
        pulse(1'b0, 1'b1);
        expect_out("R10 reti frees level2", 1'b1, 5);
        pulse(1'b0, 1'b1);
        expect_out("R10 second reti", 1'b1, 5);
        pulse(1'b1, 1'b1);
        drive(13'h0050, 13'h0040, '0);
        expect_out("R11 level2 in service", 1'b0, 0);
        drive(13'h1050, 13'h1040, 13'h1000);
        expect_out("R11 level3 still passes", 1'b1, 12);
        drive(13'h0050, 13'h0040, '0);
        pulse(1'b0, 1'b1);
        expect_out("R10 all retired", 1'b1, 6);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule